// File: doc/BRIEF.md
# Seconds Counter with Alarm and Tick Interrupts

This block is a bus-attached real-time clock. A programmable prescaler divides the block clock, which is nominally 32.768 kHz, down to a once-per-second tick. A drift-correction field stretches or shrinks one prescaler period out of every group of `TRIM_INTERVAL`. Each tick advances a 32-bit seconds counter that software can load with any value. A 32-bit alarm register is compared against the counter.

A single status word holds both the interrupt enables and two sticky event flags. The flags are cleared by writing one to them. Two level interrupt outputs are driven, one for the tick and one for the alarm.

The register port takes one cycle. A write is taken at the clock edge on which `bus_we` is high. Read data is combinational from `bus_addr`. A parameter chooses between two address layouts. After reset the divider field is zero and the prescaler stays idle until software writes a nonzero divider.

Top module: `rtc_alarm_top`

## Requirements
- R1: After reset every register reads zero and both interrupt outputs are low.
- R2: While the divider field is zero, no tick is produced and the seconds counter holds its value.
- R3: With divider D (nonzero) and no trim applied, a tick occurs every D+1 cycles. Each tick adds one to the seconds counter. Writing the divider/trim register restarts the prescaler phase, so the first tick comes D+1 cycles after the write edge.
- R4: The trim is a signed 10-bit value in bits 25:16 of the divider/trim register. Within each group of `TRIM_INTERVAL` prescaler periods, the last one lasts D+1+trim cycles, with a floor of two cycles. The group count restarts on a divider/trim write.
- R5: Software may load any 32-bit value into the seconds counter, including zero. A load on the same edge as a tick wins, and that tick is dropped.
- R6: Status bit 0 (alarm flag) is set one cycle after the counter and the alarm register become equal. It is set whether or not the alarm enable is set.
- R7: Status bit 1 (tick flag) is set on the rising edge of each tick, on the same edge that advances the counter.
- R8: Writing 1 to status bit 0 or bit 1 clears that flag, and writing 0 leaves it unchanged. Status bits 2 (alarm enable) and 3 (tick enable) are plain read/write bits.
- R9: When a flag's set event and a write-one-to-clear of the same flag land on the same edge, the flag ends up set.
- R10: `irq_alarm` is high exactly while status bits 0 and 2 are both set. `irq_tick` is high exactly while status bits 1 and 3 are both set.
- R11: With `ALT_MAP`=0 the byte offsets are: alarm 0x00, counter 0x04, divider/trim 0x08, status 0x10. With `ALT_MAP`=1 they are: counter 0x00, alarm 0x04, status 0x08, divider/trim 0x0C. Any other offset reads zero and ignores writes.
- R12: The divider/trim register reads back the divider in bits 15:0 and the trim in bits 25:16. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, nominally 32.768 kHz |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the accessed register |
| bus_we | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_tick | output | 1 | Tick interrupt: tick flag and tick enable both set |
| irq_alarm | output | 1 | Alarm interrupt: alarm flag and alarm enable both set |

## Verification
A wrong prescaler phase or group count never shows as a bad value. It shows as a counter that advances one or more cycles early or late. The bench therefore samples the counter on the cycle just before and the cycle just after each expected tick, for both plain and trimmed periods. A flag edge detector that is off by one either sets a flag a cycle late or loses it when it collides with a clear. These faults show at the status read and at the interrupt pins within one cycle of the event. A decoding mistake shows at once as a wrong readback, or as a write that lands on a register it should not reach.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

   typedef enum logic [1:0] {
      REG_ALARM   = 2'd0,
      REG_COUNT   = 2'd1,
      REG_DIVTRIM = 2'd2,
      REG_STATUS  = 2'd3
   } rtc_reg_e;

   localparam int STAT_W    = 4;
   localparam int TRIM_LSB  = 16;
   localparam int MIN_ADDRW = 5;

   // byte offset of each register in either layout
   function automatic logic [7:0] reg_offset(rtc_reg_e r, bit alt);
      logic [7:0] off;
      if (!alt) begin
         case (r)
            REG_ALARM:   off = 8'h00;
            REG_COUNT:   off = 8'h04;
            REG_DIVTRIM: off = 8'h08;
            default:     off = 8'h10;
         endcase
      end else begin
         case (r)
            REG_COUNT:   off = 8'h00;
            REG_ALARM:   off = 8'h04;
            REG_STATUS:  off = 8'h08;
            default:     off = 8'h0C;
         endcase
      end
      return off;
   endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int DIV_W         = 16,
   parameter int TRIM_W        = 10,
   parameter int TRIM_INTERVAL = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic [DIV_W-1:0]  div,
   input  logic [TRIM_W-1:0] trim,
   output logic              tick_o
);
   localparam int PC_W  = DIV_W + 1;
   localparam int SUM_W = DIV_W + 2;
   localparam int TC_W  = $clog2(TRIM_INTERVAL);
   localparam logic [TC_W-1:0]         TC_LAST = TC_W'(TRIM_INTERVAL - 1);
   localparam logic signed [SUM_W-1:0] TERM_MIN = SUM_W'(1);

   initial begin
      assert (TRIM_INTERVAL >= 2 && (TRIM_INTERVAL & (TRIM_INTERVAL - 1)) == 0)
         else $error("TRIM_INTERVAL must be a power of two, at least 2");
      assert (TRIM_W < SUM_W) else $error("TRIM_W too wide for DIV_W");
   end

   logic [PC_W-1:0]         pc_q;
   logic [TC_W-1:0]         tc_q;
   logic signed [SUM_W-1:0] trim_ext;
   logic signed [SUM_W-1:0] sum;
   logic [PC_W-1:0]         term;
   logic                    active;
   logic                    trim_now;

   assign active   = |div;
   assign trim_now = (tc_q == TC_LAST);
   assign trim_ext = {{(SUM_W-TRIM_W){trim[TRIM_W-1]}}, trim};

   always_comb begin
      sum = $signed({2'b00, div});
      if (trim_now) sum = sum + trim_ext;
      // floor keeps every period at two cycles or more
      if (sum < TERM_MIN) term = PC_W'(1);
      else                term = sum[PC_W-1:0];
   end

   assign tick_o = active && (pc_q >= term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= '0;
         tc_q <= '0;
      end else if (restart || !active) begin
         pc_q <= '0;
         tc_q <= '0;
      end else if (tick_o) begin
         pc_q <= '0;
         tc_q <= tc_q + 1'b1;
      end else begin
         pc_q <= pc_q + 1'b1;
      end
   end

   // phase never runs past the end of the current period
   assert_phase_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> pc_q <= term);

   // a tick always starts a fresh period
   assert_phase_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> pc_q == '0);

endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             we_cnt,
   input  logic             we_alm,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] alm_o,
   output logic             match_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] alm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (we_cnt) cnt_q <= wdata;   // software load beats the tick
      else if (tick)   cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      alm_q <= '0;
      else if (we_alm) alm_q <= wdata;
   end

   assign cnt_o   = cnt_q;
   assign alm_o   = alm_q;
   assign match_o = (cnt_q == alm_q);

   assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !we_cnt |=> cnt_q == $past(cnt_q) + 1'b1);

   assert_load_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      we_cnt |=> cnt_q == $past(wdata));

endmodule

// File: rtl/rtc_status.sv
module rtc_status import rtc_alarm_pkg::*; (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              match,
   input  logic              we,
   input  logic [STAT_W-1:0] wdata,
   output logic [STAT_W-1:0] stat_o,
   output logic              irq_tick,
   output logic              irq_alarm
);
   logic tick_q;
   logic match_q;
   logic hz_set;
   logic al_set;
   logic al_flag_q;
   logic hz_flag_q;
   logic al_en_q;
   logic hz_en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q  <= 1'b0;
         match_q <= 1'b1;   // registers are equal out of reset: no event
      end else begin
         tick_q  <= tick;
         match_q <= match;
      end
   end

   assign hz_set = tick & ~tick_q;
   assign al_set = match & ~match_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         al_en_q <= 1'b0;
         hz_en_q <= 1'b0;
      end else if (we) begin
         al_en_q <= wdata[2];
         hz_en_q <= wdata[3];
      end
   end

   // set dominates a same-edge clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 al_flag_q <= 1'b0;
      else if (al_set)            al_flag_q <= 1'b1;
      else if (we && wdata[0])    al_flag_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 hz_flag_q <= 1'b0;
      else if (hz_set)            hz_flag_q <= 1'b1;
      else if (we && wdata[1])    hz_flag_q <= 1'b0;
   end

   assign stat_o    = {hz_en_q, al_en_q, hz_flag_q, al_flag_q};
   assign irq_tick  = hz_flag_q & hz_en_q;
   assign irq_alarm = al_flag_q & al_en_q;

   assert_tick_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hz_set |=> hz_flag_q);

   assert_alarm_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      al_set |=> al_flag_q);

   assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      we && wdata[0] && !al_set |=> !al_flag_q);

   assert_w0_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && wdata[1]) && hz_flag_q |=> hz_flag_q);

endmodule

// File: rtl/rtc_alarm_top.sv
module rtc_alarm_top import rtc_alarm_pkg::*; #(
   parameter int ADDR_W        = 8,
   parameter int DIV_W         = 16,
   parameter int TRIM_W        = 10,
   parameter int TRIM_INTERVAL = 1024,
   parameter bit ALT_MAP       = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq_tick,
   output logic              irq_alarm
);
   localparam int TRIM_VW = (TRIM_W > 0) ? TRIM_W : 1;
   localparam logic [ADDR_W-1:0] A_ALM = ADDR_W'(reg_offset(REG_ALARM,   ALT_MAP));
   localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(reg_offset(REG_COUNT,   ALT_MAP));
   localparam logic [ADDR_W-1:0] A_DIV = ADDR_W'(reg_offset(REG_DIVTRIM, ALT_MAP));
   localparam logic [ADDR_W-1:0] A_STA = ADDR_W'(reg_offset(REG_STATUS,  ALT_MAP));

   initial begin
      assert (ADDR_W >= MIN_ADDRW) else $error("ADDR_W too narrow for the map");
      assert (DIV_W >= 1 && DIV_W <= TRIM_LSB) else $error("DIV_W out of range");
      assert (TRIM_W >= 0 && TRIM_W <= 32 - TRIM_LSB) else $error("TRIM_W out of range");
   end

   logic              we_alm, we_cnt, we_div, we_sta;
   logic [DIV_W-1:0]  div_q;
   logic [TRIM_VW-1:0] trim_q;
   logic [31:0]       divtrim_rd;
   logic [31:0]       cnt, alm;
   logic              match;
   logic              tick;
   logic [STAT_W-1:0] stat;

   assign we_alm = bus_we && (bus_addr == A_ALM);
   assign we_cnt = bus_we && (bus_addr == A_CNT);
   assign we_div = bus_we && (bus_addr == A_DIV);
   assign we_sta = bus_we && (bus_addr == A_STA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      div_q <= '0;
      else if (we_div) div_q <= bus_wdata[DIV_W-1:0];
   end

   generate
      if (TRIM_W > 0) begin : g_trim
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      trim_q <= '0;
            else if (we_div) trim_q <= bus_wdata[TRIM_LSB +: TRIM_VW];
         end
      end else begin : g_no_trim
         assign trim_q = '0;
      end
   endgenerate

   always_comb begin
      divtrim_rd = '0;
      divtrim_rd[DIV_W-1:0] = div_q;
      if (TRIM_W > 0) divtrim_rd[TRIM_LSB +: TRIM_VW] = trim_q;
   end

   rtc_prescaler #(
      .DIV_W         (DIV_W),
      .TRIM_W        (TRIM_VW),
      .TRIM_INTERVAL (TRIM_INTERVAL)
   ) u_prescaler (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (we_div),
      .div     (div_q),
      .trim    (trim_q),
      .tick_o  (tick)
   );

   rtc_seconds #(.CNT_W(32)) u_seconds (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .we_cnt  (we_cnt),
      .we_alm  (we_alm),
      .wdata   (bus_wdata),
      .cnt_o   (cnt),
      .alm_o   (alm),
      .match_o (match)
   );

   rtc_status u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .match     (match),
      .we        (we_sta),
      .wdata     (bus_wdata[STAT_W-1:0]),
      .stat_o    (stat),
      .irq_tick  (irq_tick),
      .irq_alarm (irq_alarm)
   );

   always_comb begin
      if      (bus_addr == A_ALM) bus_rdata = alm;
      else if (bus_addr == A_CNT) bus_rdata = cnt;
      else if (bus_addr == A_DIV) bus_rdata = divtrim_rd;
      else if (bus_addr == A_STA) bus_rdata = {{(32-STAT_W){1'b0}}, stat};
      else                        bus_rdata = '0;
   end

   // idle prescaler leaves the counter alone
   assert_idle_holds_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (div_q == '0) && !we_cnt && !we_div |=> $stable(cnt));

   // an interrupt line needs its enable in the status word
   assert_alarm_irq_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_alarm |-> bus_addr != A_STA || bus_rdata[2]);

endmodule

// File: tb/rtc_alarm_top_tb.sv
module rtc_alarm_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rdata, rdata_alt;
   logic        irq_tick, irq_alarm, irq_tick_alt, irq_alarm_alt;
   int          n_checks = 0;
   int          n_fail = 0;
   logic [31:0] v;

   always #5 clk = ~clk;

   rtc_alarm_top #(.TRIM_INTERVAL(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(rdata),
      .irq_tick(irq_tick), .irq_alarm(irq_alarm));

   rtc_alarm_top #(.TRIM_INTERVAL(4), .ALT_MAP(1'b1)) u_dut_alt (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(rdata_alt),
      .irq_tick(irq_tick_alt), .irq_alarm(irq_alarm_alt));

   localparam logic [7:0] O_ALM = 8'h00, O_CNT = 8'h04, O_DIV = 8'h08, O_STA = 8'h10;

   typedef struct packed {
      logic [7:0]  a;
      logic [31:0] w;
      logic [31:0] e;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{O_ALM, 32'h1234_5678, 32'h1234_5678},   // R11
      '{O_CNT, 32'hFFFF_FFFF, 32'hFFFF_FFFF},   // R5
      '{O_DIV, 32'hFFFF_FFFF, 32'h03FF_FFFF},   // R12
      '{O_DIV, 32'h0000_0000, 32'h0000_0000},   // R12
      '{O_STA, 32'h0000_000C, 32'h0000_000C},   // R8
      '{O_STA, 32'h0000_0000, 32'h0000_0000},   // R8
      '{8'h0C, 32'h0000_DEAD, 32'h0000_0000},   // R11
      '{O_CNT, 32'h0000_0000, 32'h0000_0000}    // R5
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = rdata;
   endtask

   task automatic rd_alt(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = rdata_alt;
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(100000 * 10);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      finish_run();
   end

   initial begin
      cycles(3);
      rst_n = 1'b1;
      cycles(1);

      // R1 reset state
      rd(O_ALM, v); check("R1 alarm", v, 0);
      rd(O_CNT, v); check("R1 counter", v, 0);
      rd(O_DIV, v); check("R1 divtrim", v, 0);
      rd(O_STA, v); check("R1 status", v, 0);
      check("R1 irqs", {30'd0, irq_tick, irq_alarm}, 0);

      // R2 idle prescaler
      cycles(50);
      rd(O_CNT, v); check("R2 counter held", v, 0);

      // register table
      foreach (VECS[i]) begin
         wr(VECS[i].a, VECS[i].w);
         rd(VECS[i].a, v);
         check("R11/R12 table", v, VECS[i].e);
      end

      // R3 period D+1, R7 tick flag
      wr(O_CNT, 32'd100);
      wr(O_DIV, 32'd9);
      cycles(9);
      rd(O_CNT, v); check("R3 before tick", v, 100);
      cycles(1);
      rd(O_CNT, v); check("R3 first tick", v, 101);
      rd(O_STA, v); check("R7 tick flag", v, 32'h2);
      cycles(10);
      rd(O_CNT, v); check("R3 second tick", v, 102);

      // R9 set beats same-edge clear
      cycles(9);
      wr(O_STA, 32'h2);
      rd(O_STA, v); check("R9 set priority", v, 32'h2);
      rd(O_CNT, v); check("R3 third tick", v, 103);
      wr(O_STA, 32'h2);
      rd(O_STA, v); check("R8 w1c tick flag", v, 32'h0);

      // R5 load on tick edge wins
      wr(O_DIV, 32'd9);
      cycles(9);
      wr(O_CNT, 32'h55);
      rd(O_CNT, v); check("R5 load beats tick", v, 32'h55);
      cycles(10);
      rd(O_CNT, v); check("R5 count after load", v, 32'h56);

      // R4 positive trim: periods 10,10,10,13
      wr(O_CNT, 32'd0);
      wr(O_DIV, (32'd3 << 16) | 32'd9);
      cycles(42);
      rd(O_CNT, v); check("R4 plus trim before", v, 3);
      cycles(1);
      rd(O_CNT, v); check("R4 plus trim after", v, 4);

      // R4 negative trim -4: periods 10,10,10,6
      wr(O_CNT, 32'd0);
      wr(O_DIV, (32'h3FC << 16) | 32'd9);
      cycles(35);
      rd(O_CNT, v); check("R4 minus trim before", v, 3);
      cycles(1);
      rd(O_CNT, v); check("R4 minus trim after", v, 4);

      wr(O_DIV, 32'd0);
      wr(O_STA, 32'h3);

      // R6 alarm flag without enable
      rd(O_CNT, v);
      wr(O_ALM, v);
      rd(O_STA, v); check("R6 flag not yet", v, 0);
      cycles(1);
      rd(O_STA, v); check("R6 flag set", v, 32'h1);
      check("R10 alarm irq masked", {31'd0, irq_alarm}, 0);

      // R10 enable, R8 write-zero keeps flag
      wr(O_STA, 32'h4);
      rd(O_STA, v); check("R8 flag kept", v, 32'h5);
      check("R10 alarm irq on", {31'd0, irq_alarm}, 1);
      wr(O_STA, 32'h5);
      rd(O_STA, v); check("R8 alarm w1c", v, 32'h4);
      check("R10 alarm irq off", {31'd0, irq_alarm}, 0);

      // R10 tick interrupt
      wr(O_STA, 32'h8);
      check("R10 tick irq no flag", {31'd0, irq_tick}, 0);
      wr(O_DIV, 32'd1);
      cycles(1);
      check("R10 tick irq early", {31'd0, irq_tick}, 0);
      cycles(1);
      check("R10 tick irq on", {31'd0, irq_tick}, 1);
      wr(O_DIV, 32'd0);
      wr(O_STA, 32'hA);
      check("R10 tick irq cleared", {31'd0, irq_tick}, 0);

      // R11 alternate layout
      wr(8'h0C, 32'h0005_0000);
      wr(8'h00, 32'hAAAA_0001);
      wr(8'h04, 32'hBBBB_0002);
      wr(8'h08, 32'h3);
      rd_alt(8'h00, v); check("R11 alt counter", v, 32'hAAAA_0001);
      rd_alt(8'h04, v); check("R11 alt alarm", v, 32'hBBBB_0002);
      rd_alt(8'h0C, v); check("R11 alt divtrim", v, 32'h0005_0000);
      rd_alt(8'h08, v); check("R11 alt status", v, 32'h0);
      rd_alt(8'h10, v); check("R11 alt unused", v, 32'h0);

      finish_run();
   end

endmodule